// File: doc/BRIEF.md
# Variable-Page-Size Fully Associative Translation Buffer

This block is a fully associative translation buffer with a fixed population of 64 entries. Each entry pairs a 64-bit tag word with a 64-bit translation word. The translation word carries a valid flag in its top bit and a two-bit page-size code just below it. The block has three access paths. A diagnostic write port loads the tag and translation words of one entry, chosen by an index. A diagnostic read port returns the translation word held at an index. An associative lookup port compares an incoming tag-format address against every valid entry. It returns the translation word of the lowest-numbered entry that matches.

The comparison is not a plain equality test. The size code of each entry builds a mask that drops a band of bits, starting at bit 12 and ending at a top bit set by the size. The tag and the address are both masked before they are compared. A larger page therefore matches a wider range of addresses. The low 12 bits and every bit above the band are always part of the compare. Lookups and diagnostic reads both give registered results one cycle after their request strobes.

Top module: `vpt_tlb`

## Requirements
- R1: A diagnostic write (`wr_en` high) loads `wr_tag` and `wr_tte` into the entry whose index is `wr_addr[8:3]`, for any of the 64 indices. The new contents take effect at the clock edge that samples the strobe.
- R2: A diagnostic read (`rd_en` high) returns the full translation word of entry `rd_addr[8:3]` on `rd_tte`, with `rd_valid` high, one cycle after the strobe. `rd_valid` is low in any cycle that does not follow a read strobe.
- R3: A synchronous reset (`rst` high at a clock edge) clears bit 63 of every translation word and leaves all other stored bits unchanged. In the cycle after reset, `lk_valid`, `lk_hit` and `rd_valid` are all low.
- R4: An entry takes part in a lookup only when bit 63 of its translation word is 1. An entry whose bit 63 is 0 never hits, even when its tag equals the address.
- R5: Bits 62:61 of an entry's translation word select its compare mask. Code 0 compares all 64 bits. Code 1 ignores bits 15:12. Code 2 ignores bits 18:12. Code 3 ignores bits 21:12. Bits 11:0, and every bit above the ignored band, are always compared.
- R6: A lookup hit returns the translation word of the matching entry, not its tag.
- R7: When more than one valid entry matches, the lookup returns the entry with the lowest index.
- R8: When no valid entry matches, the lookup result has `lk_hit` low and `lk_tte` equal to zero.
- R9: A lookup strobe (`lk_en`) produces `lk_valid` high one cycle later, together with that lookup's `lk_hit` and `lk_tte`. `lk_valid` is low after a cycle that has no strobe.
- R10: A lookup or diagnostic read in the same cycle as a diagnostic write sees the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; invalidates every entry |
| wr_en | input | 1 | Diagnostic write strobe |
| wr_addr | input | 64 | Write address; bits 8:3 give the entry index |
| wr_tag | input | 64 | Tag word to store |
| wr_tte | input | 64 | Translation word to store |
| rd_en | input | 1 | Diagnostic read strobe |
| rd_addr | input | 64 | Read address; bits 8:3 give the entry index |
| rd_tte | output | 64 | Translation word returned by the read |
| rd_valid | output | 1 | High one cycle after a read strobe |
| lk_en | input | 1 | Associative lookup strobe |
| lk_addr | input | 64 | Tag-format address to look up |
| lk_tte | output | 64 | Translation word of the winning entry, zero on a miss |
| lk_hit | output | 1 | A valid entry matched |
| lk_valid | output | 1 | High one cycle after a lookup strobe |

## Verification
The hardest case to reach from the ports is a single cycle that holds a write, a read and a lookup all aimed at the same entry. In that cycle the old contents must win over the new ones. The stimulus fills an entry, then raises all three strobes together in one cycle, and checks both registered outputs against the pre-write word before it reads the entry again. The mask bands need addresses that differ from a stored tag only just inside and just outside each size's ignored range. The bench flips exactly those bits. Priority between entries is forced by giving two entries the same tag, with the higher index written first.

// File: rtl/vpt_tlb_pkg.sv
package vpt_tlb_pkg;

    localparam int unsigned WORD_W    = 64;
    localparam int unsigned VALID_BIT = WORD_W - 1;
    localparam int unsigned SIZE_HI   = WORD_W - 2;
    localparam int unsigned SIZE_LO   = WORD_W - 3;
    localparam int unsigned BAND_LSB  = 12;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [1:0]        size_code_t;

    // Top bit of the ignored band for each size code
    function automatic int unsigned band_top(input size_code_t code);
        case (code)
            2'd1:    band_top = 15;
            2'd2:    band_top = 18;
            2'd3:    band_top = 21;
            default: band_top = 0;
        endcase
    endfunction

    // Compare mask: ones where bits take part in the comparison
    function automatic word_t size_mask(input size_code_t code);
        word_t m;
        int unsigned top;
        m   = '1;
        top = band_top(code);
        if (code != 2'd0) begin
            for (int unsigned b = BAND_LSB; b < WORD_W; b++) begin
                if (b <= top) m[b] = 1'b0;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/vpt_tlb_store.sv
module vpt_tlb_store
    import vpt_tlb_pkg::*;
#(
    parameter int unsigned N_ENTRIES = 64,
    localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  word_t                       wr_tag,
    input  word_t                       wr_tte,
    output logic [N_ENTRIES-1:0][WORD_W-1:0] tag_q,
    output logic [N_ENTRIES-1:0][WORD_W-1:0] tte_q
);

    typedef struct packed {
        logic [N_ENTRIES-1:0][WORD_W-1:0] tag;
        logic [N_ENTRIES-1:0][WORD_W-1:0] tte;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            for (int i = 0; i < int'(N_ENTRIES); i++) begin
                st_d.tte[i][VALID_BIT] = 1'b0;
            end
        end else if (wr_en) begin
            st_d.tag[wr_idx] = wr_tag;
            st_d.tte[wr_idx] = wr_tte;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign tag_q = st_q.tag;
    assign tte_q = st_q.tte;

endmodule

// File: rtl/vpt_tlb_match.sv
module vpt_tlb_match
    import vpt_tlb_pkg::*;
#(
    parameter int unsigned N_ENTRIES = 64
) (
    input  logic [N_ENTRIES-1:0][WORD_W-1:0] tag_q,
    input  logic [N_ENTRIES-1:0][WORD_W-1:0] tte_q,
    input  word_t                            addr,
    output logic [N_ENTRIES-1:0]             hit_vec
);

    for (genvar g = 0; g < int'(N_ENTRIES); g++) begin : g_entry
        word_t      mask_w;
        size_code_t code_w;
        logic       valid_w;

        always_comb begin
            code_w     = tte_q[g][SIZE_HI:SIZE_LO];
            valid_w    = tte_q[g][VALID_BIT];
            mask_w     = size_mask(code_w);
            hit_vec[g] = valid_w && ((tag_q[g] & mask_w) == (addr & mask_w));
        end
    end

endmodule

// File: rtl/vpt_tlb_select.sv
module vpt_tlb_select
    import vpt_tlb_pkg::*;
#(
    parameter int unsigned N_ENTRIES = 64
) (
    input  logic [N_ENTRIES-1:0]             hit_vec,
    input  logic [N_ENTRIES-1:0][WORD_W-1:0] tte_q,
    output logic                             any_hit,
    output word_t                            sel_tte
);

    // Scan from the top so the lowest index is the last to be taken
    always_comb begin
        any_hit = 1'b0;
        sel_tte = '0;
        for (int i = int'(N_ENTRIES) - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                sel_tte = tte_q[i];
            end
        end
    end

endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
    import vpt_tlb_pkg::*;
#(
    parameter int unsigned N_ENTRIES = 64,
    parameter int unsigned IDX_LSB   = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [63:0] wr_addr,
    input  logic [63:0] wr_tag,
    input  logic [63:0] wr_tte,
    input  logic        rd_en,
    input  logic [63:0] rd_addr,
    output logic [63:0] rd_tte,
    output logic        rd_valid,
    input  logic        lk_en,
    input  logic [63:0] lk_addr,
    output logic [63:0] lk_tte,
    output logic        lk_hit,
    output logic        lk_valid
);

    localparam int unsigned IDX_W   = $clog2(N_ENTRIES);
    localparam int unsigned IDX_MSB = IDX_LSB + IDX_W - 1;

    typedef struct packed {
        word_t rd_tte;
        logic  rd_valid;
        word_t lk_tte;
        logic  lk_hit;
        logic  lk_valid;
    } out_t;

    logic [N_ENTRIES-1:0][WORD_W-1:0] tag_q;
    logic [N_ENTRIES-1:0][WORD_W-1:0] tte_q;
    logic [N_ENTRIES-1:0]             hit_vec;
    logic                             any_hit;
    word_t                            sel_tte;
    logic [IDX_W-1:0]                 wr_idx;
    logic [IDX_W-1:0]                 rd_idx;

    out_t o_d, o_q;

    assign wr_idx = wr_addr[IDX_MSB:IDX_LSB];
    assign rd_idx = rd_addr[IDX_MSB:IDX_LSB];

    vpt_tlb_store #(.N_ENTRIES(N_ENTRIES)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_tag (wr_tag),
        .wr_tte (wr_tte),
        .tag_q  (tag_q),
        .tte_q  (tte_q)
    );

    vpt_tlb_match #(.N_ENTRIES(N_ENTRIES)) u_match (
        .tag_q   (tag_q),
        .tte_q   (tte_q),
        .addr    (lk_addr),
        .hit_vec (hit_vec)
    );

    vpt_tlb_select #(.N_ENTRIES(N_ENTRIES)) u_select (
        .hit_vec (hit_vec),
        .tte_q   (tte_q),
        .any_hit (any_hit),
        .sel_tte (sel_tte)
    );

    always_comb begin
        o_d          = o_q;
        o_d.rd_valid = 1'b0;
        o_d.lk_valid = 1'b0;
        if (rst) begin
            o_d = '0;
        end else begin
            if (rd_en) begin
                o_d.rd_valid = 1'b1;
                o_d.rd_tte   = tte_q[rd_idx];
            end
            if (lk_en) begin
                o_d.lk_valid = 1'b1;
                o_d.lk_hit   = any_hit;
                o_d.lk_tte   = any_hit ? sel_tte : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        o_q <= o_d;
    end

    assign rd_tte   = o_q.rd_tte;
    assign rd_valid = o_q.rd_valid;
    assign lk_tte   = o_q.lk_tte;
    assign lk_hit   = o_q.lk_hit;
    assign lk_valid = o_q.lk_valid;

endmodule

// File: rtl/vpt_tlb_checker.sv
module vpt_tlb_checker #(
    parameter int unsigned N_ENTRIES = 64
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rd_en,
    input logic                 rd_valid,
    input logic                 lk_en,
    input logic                 lk_valid,
    input logic                 lk_hit,
    input logic [63:0]          lk_tte,
    input logic [N_ENTRIES-1:0] hit_vec
);

    p_read_latency_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    p_read_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    p_reset_quiet_r3: assert property (@(posedge clk)
        rst |=> (!lk_valid && !lk_hit && !rd_valid));

    p_hit_is_valid_r4: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_hit) |-> lk_tte[63]);

    p_hit_tracks_match_r7: assert property (@(posedge clk) disable iff (rst)
        lk_en |=> (lk_hit == $past(|hit_vec)));

    p_miss_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_hit) |-> (lk_tte == 64'd0));

    p_lookup_latency_r9: assert property (@(posedge clk) disable iff (rst)
        lk_en |=> lk_valid);

    p_lookup_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !lk_en |=> !lk_valid);

endmodule

bind vpt_tlb vpt_tlb_checker #(.N_ENTRIES(N_ENTRIES)) u_checker (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .lk_en    (lk_en),
    .lk_valid (lk_valid),
    .lk_hit   (lk_hit),
    .lk_tte   (lk_tte),
    .hit_vec  (hit_vec)
);

// File: tb/vpt_tlb_test.sv
module vpt_tlb_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [63:0] wr_addr, wr_tag, wr_tte;
    logic        rd_en;
    logic [63:0] rd_addr;
    logic [63:0] rd_tte;
    logic        rd_valid;
    logic        lk_en;
    logic [63:0] lk_addr;
    logic [63:0] lk_tte;
    logic        lk_hit, lk_valid;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    vpt_tlb uut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_tag(wr_tag), .wr_tte(wr_tte),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_tte(rd_tte), .rd_valid(rd_valid),
        .lk_en(lk_en), .lk_addr(lk_addr), .lk_tte(lk_tte), .lk_hit(lk_hit),
        .lk_valid(lk_valid)
    );

    function automatic logic [63:0] mk_tte(input logic v, input logic [1:0] sz,
                                           input logic [60:0] body);
        return {v, sz, body};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; rd_en = 0; lk_en = 0; rst = 0;
        wr_addr = '0; wr_tag = '0; wr_tte = '0; rd_addr = '0; lk_addr = '0;
    endtask

    // One cycle: inputs driven at negedge, outputs sampled at following negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_write(input int idx, input logic [63:0] tag, input logic [63:0] tte);
        wr_en = 1; wr_addr = 64'(idx) << 3; wr_tag = tag; wr_tte = tte;
        step();
    endtask

    task automatic read_expect(input string req, input int idx, input logic [63:0] exp);
        rd_en = 1; rd_addr = (64'(idx) << 3) | 64'h7;
        step();
        check(req, {63'd0, rd_valid}, 64'd1);
        check(req, rd_tte, exp);
    endtask

    task automatic lookup_expect(input string req, input logic [63:0] addr,
                                 input logic hit, input logic [63:0] exp);
        lk_en = 1; lk_addr = addr;
        step();
        check(req, {63'd0, lk_valid}, 64'd1);
        check(req, {63'd0, lk_hit}, {63'd0, hit});
        check(req, lk_tte, exp);
    endtask

    localparam logic [63:0] TAG_A = 64'h0000_1234_5678_9ABC;
    localparam logic [63:0] TAG_B = 64'h0000_0AAA_0000_0555;
    localparam logic [63:0] TAG_C = 64'h0000_0BBB_0000_0666;
    localparam logic [63:0] TAG_D = 64'h0000_0CCC_0000_0777;
    localparam logic [63:0] TAG_E = 64'h0000_0DDD_0000_0888;
    localparam logic [63:0] TAG_F = 64'h0000_0EEE_0000_0999;

    task automatic t_reset();
        rst = 1; step(); rst = 1; step();
        check("R3 reset lk_valid", {63'd0, lk_valid}, 64'd0);
        check("R3 reset rd_valid", {63'd0, rd_valid}, 64'd0);
        check("R9 no strobe lk_valid", {63'd0, lk_valid}, 64'd0);
        lookup_expect("R3 empty after reset", 64'd0, 1'b0, 64'd0);
    endtask

    task automatic t_write_read();
        logic [63:0] t5 = mk_tte(1, 2'd0, 61'h111);
        do_write(5, TAG_A, t5);
        read_expect("R1 R2 read back entry 5", 5, t5);
        do_write(63, TAG_F, mk_tte(0, 2'd3, 61'h3F));
        read_expect("R1 top index 63", 63, mk_tte(0, 2'd3, 61'h3F));
        step();
        check("R2 rd_valid idle", {63'd0, rd_valid}, 64'd0);
    endtask

    task automatic t_exact();
        lookup_expect("R6 exact hit returns tte", TAG_A, 1'b1, mk_tte(1, 2'd0, 61'h111));
        lookup_expect("R5 code0 bit12 compared", TAG_A ^ (64'd1 << 12), 1'b0, 64'd0);
        lookup_expect("R8 miss low bit", TAG_A ^ 64'd1, 1'b0, 64'd0);
    endtask

    task automatic t_sizes();
        logic [63:0] t1 = mk_tte(1, 2'd1, 61'h222);
        logic [63:0] t2 = mk_tte(1, 2'd2, 61'h333);
        logic [63:0] t3 = mk_tte(1, 2'd3, 61'h444);
        do_write(10, TAG_B, t1);
        do_write(20, TAG_C, t2);
        do_write(30, TAG_D, t3);
        lookup_expect("R5 code1 band ignored", TAG_B ^ (64'hF << 12), 1'b1, t1);
        lookup_expect("R5 code1 bit16 compared", TAG_B ^ (64'd1 << 16), 1'b0, 64'd0);
        lookup_expect("R5 code1 bit11 compared", TAG_B ^ (64'd1 << 11), 1'b0, 64'd0);
        lookup_expect("R5 code2 band ignored", TAG_C ^ (64'h7F << 12), 1'b1, t2);
        lookup_expect("R5 code2 bit19 compared", TAG_C ^ (64'd1 << 19), 1'b0, 64'd0);
        lookup_expect("R5 code3 band ignored", TAG_D ^ (64'h3FF << 12), 1'b1, t3);
        lookup_expect("R5 code3 bit22 compared", TAG_D ^ (64'd1 << 22), 1'b0, 64'd0);
        lookup_expect("R5 code3 bit0 compared", TAG_D ^ 64'd1, 1'b0, 64'd0);
    endtask

    task automatic t_invalid();
        do_write(40, TAG_E, mk_tte(0, 2'd0, 61'h555));
        lookup_expect("R4 invalid entry never hits", TAG_E, 1'b0, 64'd0);
    endtask

    task automatic t_priority();
        logic [63:0] hi = mk_tte(1, 2'd0, 61'h650);
        logic [63:0] lo = mk_tte(1, 2'd0, 61'h645);
        do_write(50, 64'h0000_0F0F_0000_0ABC, hi);
        lookup_expect("R7 single entry", 64'h0000_0F0F_0000_0ABC, 1'b1, hi);
        do_write(45, 64'h0000_0F0F_0000_0ABC, lo);
        lookup_expect("R7 lowest index wins", 64'h0000_0F0F_0000_0ABC, 1'b1, lo);
    endtask

    task automatic t_same_cycle();
        logic [63:0] oldv = mk_tte(1, 2'd0, 61'h111);
        logic [63:0] newv = mk_tte(1, 2'd0, 61'h999);
        wr_en = 1; wr_addr = 64'd5 << 3; wr_tag = TAG_A ^ 64'h10; wr_tte = newv;
        rd_en = 1; rd_addr = 64'd5 << 3;
        lk_en = 1; lk_addr = TAG_A;
        step();
        check("R10 read sees old", rd_tte, oldv);
        check("R10 lookup sees old hit", {63'd0, lk_hit}, 64'd1);
        check("R10 lookup sees old tte", lk_tte, oldv);
        read_expect("R10 R1 new contents after", 5, newv);
        lookup_expect("R10 old tag gone", TAG_A, 1'b0, 64'd0);
    endtask

    task automatic t_reset_keep();
        rst = 1; step();
        check("R3 lk_hit after reset", {63'd0, lk_hit}, 64'd0);
        read_expect("R3 only valid bit cleared", 5, mk_tte(0, 2'd0, 61'h999));
        lookup_expect("R3 entries invalid", TAG_A ^ 64'h10, 1'b0, 64'd0);
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_exact();
        t_sizes();
        t_invalid();
        t_priority();
        t_same_cycle();
        t_reset_keep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule